// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator

This block compares two edge streams inside a phase-locked loop: a reference stream and a delayed copy of the divided oscillator stream. Only falling transitions count. Both inputs pass through a synchroniser into the system clock domain and then through a falling-edge detector. A three-state machine records which stream arrived first. The output pin then pulls high while the variable stream leads and pulls low while the reference stream leads. The pulse lasts until the lagging edge arrives, so its width follows the phase error and its average is linear over a full cycle either way.

A precision comparator elsewhere takes over the loop once the phase error is small. It raises `fine_window` while it does so. During that time this block releases its output to high impedance. The state machine keeps tracking edges, so the output is correct again as soon as the window closes.

The tri-state pin is modelled as a level (`out_drive`) and an enable (`out_en`).

Top module: `phase_freq_cmp`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_en` and `out_drive` are both 0.
- R2: From the idle state, a falling transition on `var_in` alone makes `out_en` = 1 and `out_drive` = 1. This takes effect on the third rising clock edge after the input changes.
- R3: From the idle state, a falling transition on `ref_in` alone makes `out_en` = 1 and `out_drive` = 0, with the same three-edge latency.
- R4: In a lead state, a falling transition of the opposite stream returns the block to idle and releases the output (`out_en` = 0) with the same latency.
- R5: Falling transitions on both inputs in the same clock cycle, while idle, leave the block idle with no pulse.
- R6: Rising transitions on either input have no effect on the outputs.
- R7: In a lead state, a further falling transition of the same stream keeps the state and the output level unchanged.
- R8: While `fine_window` is 1, `out_en` is 0 in that same cycle. The state machine keeps responding to edges, and when the window closes the output follows the current state.
- R9: If the lagging edge follows the leading edge by D clock cycles, `out_en` stays at 1 for exactly D cycles.
- R10: `out_drive` is 0 whenever the output is not enabled and `fine_window` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference edge stream, acts on falling edges |
| var_in | input | 1 | Delayed variable edge stream, acts on falling edges |
| fine_window | input | 1 | 1 while the precision comparator owns the loop |
| out_drive | output | 1 | Output level when enabled: 1 = pull up, 0 = pull down |
| out_en | output | 1 | Output enable; 0 = high impedance |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a falling edge on each stream: the bench drops both inputs on one clock, expects no pulse at all, and also closes a lead with the opposite edge. The second pair is a phase-detector transition while the fine window is open. The bench moves the machine into and out of a lead state under the window. It then requires the enable to stay low throughout and the output to resume at the level of the hidden state one cycle after the window closes.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        LEAD_NONE = 2'd0,
        LEAD_VAR  = 2'd1,
        LEAD_REF  = 2'd2
    } lead_e;

    typedef struct packed {
        lead_e lead;
        logic  act;
        logic  drive;
    } fsm_regs_t;

    localparam int unsigned NUM_STREAMS = 2;
    localparam int unsigned IDX_REF     = 0;
    localparam int unsigned IDX_VAR     = 1;

endpackage

// File: rtl/pfc_edge_sync.sv
module pfc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    localparam int unsigned TAP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain, din} >> 0;
        sync_d.chain = STAGES'({sync_q.chain, din});
        sync_d.last  = sync_q.chain[TAP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // High for one cycle after the synchronised level goes from 1 to 0
    assign fall = sync_q.last & ~sync_q.chain[TAP];

endmodule

// File: rtl/pfc_lead_fsm.sv
module pfc_lead_fsm
    import pfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_fall,
    input  logic  var_fall,
    output lead_e lead,
    output logic  act,
    output logic  drive
);
    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.lead)
            LEAD_NONE: begin
                if (var_fall && !ref_fall) begin
                    fsm_d.lead = LEAD_VAR;
                end else if (ref_fall && !var_fall) begin
                    fsm_d.lead = LEAD_REF;
                end
            end
            LEAD_VAR: begin
                if (ref_fall) begin
                    fsm_d.lead = LEAD_NONE;
                end
            end
            LEAD_REF: begin
                if (var_fall) begin
                    fsm_d.lead = LEAD_NONE;
                end
            end
            default: fsm_d.lead = LEAD_NONE;
        endcase
        fsm_d.act   = (fsm_d.lead != LEAD_NONE);
        fsm_d.drive = (fsm_d.lead == LEAD_VAR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{lead: LEAD_NONE, act: 1'b0, drive: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign lead  = fsm_q.lead;
    assign act   = fsm_q.act;
    assign drive = fsm_q.drive;

endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
    import pfc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic var_in,
    input  logic fine_window,
    output logic out_drive,
    output logic out_en
);
    logic [NUM_STREAMS-1:0] edge_in;
    logic [NUM_STREAMS-1:0] edge_fall;
    logic                   ref_fall;
    logic                   var_fall;
    lead_e                  lead_q;
    logic                   act_q;
    logic                   drive_q;

    always_comb begin
        edge_in          = '0;
        edge_in[IDX_REF] = ref_in;
        edge_in[IDX_VAR] = var_in;
    end

    for (genvar gi = 0; gi < NUM_STREAMS; gi++) begin : g_stream
        pfc_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_edge_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (edge_in[gi]),
            .fall  (edge_fall[gi])
        );
    end

    assign ref_fall = edge_fall[IDX_REF];
    assign var_fall = edge_fall[IDX_VAR];

    pfc_lead_fsm u_lead_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_fall (ref_fall),
        .var_fall (var_fall),
        .lead     (lead_q),
        .act      (act_q),
        .drive    (drive_q)
    );

    // The fine comparator owns the loop: release the pin at once
    assign out_en    = act_q & ~fine_window;
    assign out_drive = drive_q;

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
    import pfc_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  fine_window,
    input logic  ref_fall,
    input logic  var_fall,
    input lead_e lead_q,
    input logic  out_en,
    input logic  out_drive
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_en && !out_drive));

    p_var_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_q == LEAD_NONE && var_fall && !ref_fall) |=> (lead_q == LEAD_VAR && out_drive));

    p_ref_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_q == LEAD_NONE && ref_fall && !var_fall) |=> (lead_q == LEAD_REF && !out_drive));

    p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((lead_q == LEAD_VAR && ref_fall) || (lead_q == LEAD_REF && var_fall))
        |=> (lead_q == LEAD_NONE && !out_en));

    p_both_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_q == LEAD_NONE && ref_fall && var_fall) |=> (lead_q == LEAD_NONE && !out_en));

    p_same_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_q == LEAD_VAR && !ref_fall) |=> (lead_q == LEAD_VAR));

    p_fine_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fine_window |-> !out_en);

    p_drive_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !fine_window) |-> !out_drive);

endmodule

bind phase_freq_cmp pfc_checker i_pfc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fine_window (fine_window),
    .ref_fall    (ref_fall),
    .var_fall    (var_fall),
    .lead_q      (lead_q),
    .out_en      (out_en),
    .out_drive   (out_drive)
);

// File: tb/test_phase_freq_cmp.sv
module test_phase_freq_cmp;

    localparam int LAT = 3; // input change at a falling clock edge -> output after 3 rising edges

    typedef struct {
        int    due;
        bit    en;
        bit    drv;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b1;
    logic var_in = 1'b1;
    logic fine_window = 1'b0;
    logic out_drive;
    logic out_en;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    phase_freq_cmp i_phase_freq_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_in      (ref_in),
        .var_in      (var_in),
        .fine_window (fine_window),
        .out_drive   (out_drive),
        .out_en      (out_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int ofs, input bit en, input bit drv, input string req);
        exp_t e;
        e.due = cyc + ofs;
        e.en  = en;
        e.drv = drv;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic check_now(input bit en, input bit drv, input string req);
        n_checks++;
        if (out_en !== en || out_drive !== drv) begin
            n_fails++;
            $display("FAIL %s: out_en=%0b out_drive=%0b expected out_en=%0b out_drive=%0b",
                     req, out_en, out_drive, en, drv);
        end
    endtask

    // Monitor: pops items whose cycle has come
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check_now(e.en, e.drv, e.req);
        end
    end

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: cycle=%0d expected completion before 5000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle_cycles(3);
        check_now(1'b0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now(1'b0, 1'b0, "R1 first cycle after reset");
        idle_cycles(4);

        // R2: var falls first
        var_in = 1'b0;
        push(LAT - 1, 1'b0, 1'b0, "R2 before latency");
        push(LAT, 1'b1, 1'b1, "R2 var lead");
        idle_cycles(5);
        // R6: rising var edge ignored
        var_in = 1'b1;
        push(LAT, 1'b1, 1'b1, "R6 rising var ignored");
        push(LAT + 2, 1'b1, 1'b1, "R6 rising var ignored later");
        idle_cycles(5);
        // R7: second var fall keeps lead
        var_in = 1'b0;
        push(LAT, 1'b1, 1'b1, "R7 repeated var edge");
        push(LAT + 1, 1'b1, 1'b1, "R7 repeated var edge hold");
        idle_cycles(5);
        // R4: ref closes the lead
        ref_in = 1'b0;
        push(LAT - 1, 1'b1, 1'b1, "R4 before close");
        push(LAT, 1'b0, 1'b0, "R4 close var lead");
        idle_cycles(5);
        // R6: both rising in idle
        ref_in = 1'b1;
        var_in = 1'b1;
        push(LAT, 1'b0, 1'b0, "R6 rising both idle");
        idle_cycles(6);

        // R3 then R4 on the other side
        ref_in = 1'b0;
        push(LAT, 1'b1, 1'b0, "R3 ref lead");
        idle_cycles(4);
        var_in = 1'b0;
        push(LAT, 1'b0, 1'b0, "R4 close ref lead");
        idle_cycles(5);
        ref_in = 1'b1;
        var_in = 1'b1;
        idle_cycles(6);

        // R5: simultaneous edges
        ref_in = 1'b0;
        var_in = 1'b0;
        push(LAT, 1'b0, 1'b0, "R5 simultaneous");
        push(LAT + 1, 1'b0, 1'b0, "R5 simultaneous hold");
        push(LAT + 3, 1'b0, 1'b0, "R5 simultaneous later");
        idle_cycles(6);
        ref_in = 1'b1;
        var_in = 1'b1;
        idle_cycles(6);

        // R9: pulse width equals edge separation (D = 7)
        var_in = 1'b0;
        push(LAT - 1, 1'b0, 1'b0, "R9 width start");
        for (int k = LAT; k < LAT + 7; k++) push(k, 1'b1, 1'b1, "R9 width body");
        idle_cycles(7);
        ref_in = 1'b0;
        push(LAT, 1'b0, 1'b0, "R9 width end");
        idle_cycles(5);
        ref_in = 1'b1;
        var_in = 1'b1;
        idle_cycles(6);

        // R8: fine window over an active lead
        var_in = 1'b0;
        push(LAT, 1'b1, 1'b1, "R8 lead before window");
        idle_cycles(5);
        fine_window = 1'b1;
        push(1, 1'b0, 1'b1, "R8 window releases output");
        idle_cycles(2);
        ref_in = 1'b0;                    // closes the lead while hidden
        push(LAT + 1, 1'b0, 1'b0, "R8 state closes under window");
        idle_cycles(5);
        fine_window = 1'b0;
        push(1, 1'b0, 1'b0, "R8 idle after window");
        idle_cycles(3);
        ref_in = 1'b1;
        var_in = 1'b1;
        idle_cycles(6);
        // R8: lead entered while hidden, visible once window closes
        fine_window = 1'b1;
        var_in = 1'b0;
        push(LAT + 1, 1'b0, 1'b1, "R8 hidden var lead");
        idle_cycles(6);
        fine_window = 1'b0;
        push(1, 1'b1, 1'b1, "R8 output resumes");
        idle_cycles(3);
        ref_in = 1'b0;
        push(LAT, 1'b0, 1'b0, "R10 drive low when idle");
        idle_cycles(6);

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule